// File: doc/BRIEF.md
# Multi-Bandwidth Bit Clock Recovery Loop

This block rebuilds a bit clock from a stream of already sliced samples, one sample per clock cycle, with `OSR` samples to one bit. A phase counter runs through one bit period. Each transition in the input (a zero crossing) is compared with the point where the counter expects a bit boundary. The phase error is then fed back to the counter, with a gain that depends on the tracking mode.

Two control pins pick the mode. `acq_i` forces fast acquisition. An active-low `hold_n_i` freezes the loop so that the clock freewheels through a fade. When acquisition is released, the block schedules its own bandwidth. It runs a medium bandwidth for a fixed number of bit periods and then settles into a narrow bandwidth. The outputs are:
- a recovered clock,
- a single-cycle strobe at the middle of each recovered bit,
- the data bit captured at that strobe,
- the current mode.

The mode controller has four states: `MODE_ACQ`, `MODE_MED`, `MODE_NAR` and `MODE_HOLD`. Its transitions are:
- **force-acquire**: any state goes to `MODE_ACQ` while `acq_i`=1.
- **freeze**: `MODE_ACQ`, `MODE_MED` or `MODE_NAR` goes to `MODE_HOLD` when `acq_i`=0 and `hold_n_i`=0.
- **release-acquire**: `MODE_ACQ` goes to `MODE_MED` when both pins are 0/1.
- **narrow-down**: `MODE_MED` goes to `MODE_NAR` once the window has elapsed.
- **thaw-medium**: `MODE_HOLD` goes to `MODE_MED` if the window has not yet elapsed.
- **thaw-narrow**: `MODE_HOLD` goes to `MODE_NAR` if it has.

Top module: `bitclk_recovery`

## Requirements
- R1: `mode_o` encodes acquire as 0, medium as 1, narrow as 2 and hold as 3. It is registered, so it reflects the control pins after one clock edge. While `acq_i`=1 the mode is acquire, whatever the level of `hold_n_i`.
- R2: In acquire mode every input transition moves the phase all the way onto that transition (a correction of at most half a bit). From the first strobe after a transition, the strobe falls exactly `OSR/2` samples after the bit boundary.
- R3: A window counter starts when `acq_i` goes low and measures `NARROW_BITS*OSR` sample ticks. Until the window is complete the loop runs in medium mode, and after it the loop runs in narrow mode. With `hold_n_i`=1 throughout, the first narrow indication appears `NARROW_BITS*OSR+1` cycles after the first cycle in which `acq_i` is low. Leaving hold before the window is complete returns the loop to medium mode.
- R4: In medium mode the phase errors are collected in pairs of transitions. The mean of each pair, limited to ±`OSR/16` samples, is applied on the second transition of the pair. The strobe therefore moves by no more than `OSR/16` samples between consecutive bits. After a phase step the strobe returns to exact mid-bit.
- R5: Narrow mode works in the same way as medium mode, but the limit is ±`OSR/64` samples (at least 1) per pair.
- R6: With `acq_i`=0 and `hold_n_i`=0 the mode is hold. No correction is applied, and consecutive strobes are exactly `OSR` cycles apart whatever phase the input data has.
- R7: `data_o` takes the value of `rx_bit_i` in the cycle that `strobe_o` is high and shows it from the next cycle onwards. `rclk_o` is high in the first half of each recovered bit and low in the second half. It is low while `strobe_o` is high, and `data_o` never changes in a cycle in which `rclk_o` rises.
- R8: During reset `mode_o`=0 (acquire), `rclk_o`=1, `strobe_o`=0 and `data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit_i | input | 1 | Sliced serial data sample |
| acq_i | input | 1 | Force wide-bandwidth acquisition |
| hold_n_i | input | 1 | Active-low freeze of the phase correction |
| rclk_o | output | 1 | Recovered bit clock |
| strobe_o | output | 1 | One-cycle mid-bit sample strobe |
| data_o | output | 1 | Retimed data bit |
| mode_o | output | 2 | Tracking mode (0 acquire, 1 medium, 2 narrow, 3 hold) |

## Verification
A mode register that is wrong, or a window counter that is off by one, shows on `mode_o` one edge after the cause. The bench compares the mode against its own model of the pins and the window on every cycle, so such a fault is caught within a cycle. A fault in the phase path shows in where the strobe falls within the transmitted bit. This includes a wrong gain, a wrong clamp, a lost pair state or a correction during hold. The bench records the offset of every strobe from mid-bit, so a step that is too large or a failure to converge appears within one or two bits of the phase disturbance it injects. A capture in the wrong place shows in the cycle after the strobe, as `data_o` differing from the transmitted bit.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    typedef enum logic [1:0] {
        MODE_ACQ  = 2'd0,
        MODE_MED  = 2'd1,
        MODE_NAR  = 2'd2,
        MODE_HOLD = 2'd3
    } bcr_mode_e;

endpackage

// File: rtl/bcr_mode_fsm.sv
module bcr_mode_fsm
    import bcr_pkg::*;
#(
    parameter int OSR         = 64,
    parameter int NARROW_BITS = 30
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      acq_i,
    input  logic      hold_n_i,
    output bcr_mode_e mode_o
);

    localparam int LIM = OSR * NARROW_BITS;
    localparam int CW  = $clog2(LIM + 1);

    bcr_mode_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic            win_done;

    assign win_done = (cnt_q == CW'(LIM));

    // window counter: restarts while acquisition is forced, saturates at LIM
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (acq_i) begin
            cnt_q <= '0;
        end else if (!win_done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_ACQ;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_ACQ: begin
                if (acq_i)          state_d = MODE_ACQ;
                else if (!hold_n_i) state_d = MODE_HOLD;
                else                state_d = MODE_MED;
            end
            MODE_MED: begin
                if (acq_i)          state_d = MODE_ACQ;
                else if (!hold_n_i) state_d = MODE_HOLD;
                else if (win_done)  state_d = MODE_NAR;
                else                state_d = MODE_MED;
            end
            MODE_NAR: begin
                if (acq_i)          state_d = MODE_ACQ;
                else if (!hold_n_i) state_d = MODE_HOLD;
                else                state_d = MODE_NAR;
            end
            MODE_HOLD: begin
                if (acq_i)          state_d = MODE_ACQ;
                else if (!hold_n_i) state_d = MODE_HOLD;
                else if (win_done)  state_d = MODE_NAR;
                else                state_d = MODE_MED;
            end
            default: state_d = MODE_ACQ;
        endcase
    end

    // output process
    always_comb begin
        mode_o = state_q;
    end

    AST_ACQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        acq_i |=> (state_q == MODE_ACQ)); // R1
    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_i && !hold_n_i) |=> (state_q == MODE_HOLD)); // R6
    AST_MED_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(acq_i) && hold_n_i) |=> (state_q == MODE_MED)); // R3
    AST_NAR_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_NAR) |-> win_done); // R3

endmodule

// File: rtl/bcr_phase_det.sv
module bcr_phase_det #(
    parameter int OSR = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      din_i,
    input  logic [$clog2(OSR)-1:0]    phase_i,
    output logic                      edge_o,
    output logic signed [$clog2(OSR):0] err_o
);

    localparam int PW = $clog2(OSR);

    logic din_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= 1'b0;
        end else begin
            din_q <= din_i;
        end
    end

    // a transition is expected at phase 0; phases in the upper half read as early
    always_comb begin
        edge_o = (din_i != din_q);
        err_o  = $signed({phase_i[PW-1], phase_i});
    end

endmodule

// File: rtl/bcr_loop_filter.sv
module bcr_loop_filter
    import bcr_pkg::*;
#(
    parameter int OSR = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  bcr_mode_e                   mode_i,
    input  logic                        edge_i,
    input  logic signed [$clog2(OSR):0] err_i,
    output logic                        corr_vld_o,
    output logic [$clog2(OSR)-1:0]      corr_o
);

    localparam int PW      = $clog2(OSR);
    localparam int MED_LIM = (OSR / 16 > 0) ? OSR / 16 : 1;
    localparam int NAR_LIM = (OSR / 64 > 0) ? OSR / 64 : 1;
    localparam logic signed [PW+1:0] MED_L = (PW+2)'(MED_LIM);
    localparam logic signed [PW+1:0] NAR_L = (PW+2)'(NAR_LIM);

    logic signed [PW:0]   acc_q;
    logic                 half_q;
    logic signed [PW+1:0] sum;
    logic signed [PW+1:0] avg;
    logic signed [PW+1:0] lim;
    logic signed [PW+1:0] clamped;

    always_comb begin
        sum = $signed({acc_q[PW], acc_q}) + $signed({err_i[PW], err_i});
        avg = sum >>> 1;
        lim = (mode_i == MODE_NAR) ? NAR_L : MED_L;
        if (avg > lim)       clamped = lim;
        else if (avg < -lim) clamped = -lim;
        else                 clamped = avg;
    end

    always_comb begin
        corr_vld_o = 1'b0;
        corr_o     = '0;
        unique case (mode_i)
            MODE_ACQ: begin
                corr_vld_o = edge_i;
                corr_o     = PW'(err_i);
            end
            MODE_MED, MODE_NAR: begin
                corr_vld_o = edge_i && half_q;
                corr_o     = PW'(clamped);
            end
            MODE_HOLD: begin
                corr_vld_o = 1'b0;
            end
            default: corr_vld_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            half_q <= 1'b0;
        end else if (mode_i == MODE_ACQ || mode_i == MODE_HOLD) begin
            acc_q  <= '0;
            half_q <= 1'b0;
        end else if (edge_i) begin
            if (half_q) begin
                half_q <= 1'b0;
            end else begin
                acc_q  <= err_i;
                half_q <= 1'b1;
            end
        end
    end

    AST_NO_CORR_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_HOLD) |-> !corr_vld_o); // R6

endmodule

// File: rtl/bcr_bit_nco.sv
module bcr_bit_nco
    import bcr_pkg::*;
#(
    parameter int OSR = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  bcr_mode_e                mode_i,
    input  logic                     corr_vld_i,
    input  logic [$clog2(OSR)-1:0]   corr_i,
    input  logic                     din_i,
    output logic [$clog2(OSR)-1:0]   phase_o,
    output logic                     strobe_o,
    output logic                     rclk_o,
    output logic                     dout_o
);

    localparam int PW      = $clog2(OSR);
    localparam int HALF    = OSR / 2;
    localparam int MED_LIM = (OSR / 16 > 0) ? OSR / 16 : 1;
    localparam int NAR_LIM = (OSR / 64 > 0) ? OSR / 64 : 1;

    logic [PW-1:0] ph_q, ph_d;
    logic          rclk_q;
    logic          dout_q;
    logic          strobe;

    always_comb begin
        strobe = (ph_q == PW'(HALF));
        if (corr_vld_i) ph_d = ph_q + PW'(1) - corr_i;
        else            ph_d = ph_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            rclk_q <= 1'b1;
            dout_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            rclk_q <= (ph_d < PW'(HALF)) && !strobe;
            if (strobe) dout_q <= din_i;
        end
    end

    always_comb begin
        phase_o  = ph_q;
        strobe_o = strobe;
        rclk_o   = rclk_q;
        dout_o   = dout_q;
    end

    AST_MED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == MODE_MED) |->
        (($signed(PW'(ph_q - $past(ph_q) - PW'(1))) <= MED_LIM) &&
         ($signed(PW'(ph_q - $past(ph_q) - PW'(1))) >= -MED_LIM))); // R4
    AST_NAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == MODE_NAR) |->
        (($signed(PW'(ph_q - $past(ph_q) - PW'(1))) <= NAR_LIM) &&
         ($signed(PW'(ph_q - $past(ph_q) - PW'(1))) >= -NAR_LIM))); // R5
    AST_HOLD_FREERUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == MODE_HOLD) |-> (ph_q == PW'($past(ph_q) + PW'(1)))); // R6
    AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rclk_q) |-> $stable(dout_q)); // R7

endmodule

// File: rtl/bitclk_recovery.sv
module bitclk_recovery
    import bcr_pkg::*;
#(
    parameter int OSR         = 64,
    parameter int NARROW_BITS = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_bit_i,
    input  logic       acq_i,
    input  logic       hold_n_i,
    output logic       rclk_o,
    output logic       strobe_o,
    output logic       data_o,
    output logic [1:0] mode_o
);

    localparam int PW = $clog2(OSR);

    bcr_mode_e         mode;
    logic [PW-1:0]     phase;
    logic              edge_det;
    logic signed [PW:0] err;
    logic              corr_vld;
    logic [PW-1:0]     corr;

    bcr_mode_fsm #(.OSR(OSR), .NARROW_BITS(NARROW_BITS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq_i    (acq_i),
        .hold_n_i (hold_n_i),
        .mode_o   (mode)
    );

    bcr_phase_det #(.OSR(OSR)) u_pd (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_i   (rx_bit_i),
        .phase_i (phase),
        .edge_o  (edge_det),
        .err_o   (err)
    );

    bcr_loop_filter #(.OSR(OSR)) u_lf (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .edge_i     (edge_det),
        .err_i      (err),
        .corr_vld_o (corr_vld),
        .corr_o     (corr)
    );

    bcr_bit_nco #(.OSR(OSR)) u_nco (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .corr_vld_i (corr_vld),
        .corr_i     (corr),
        .din_i      (rx_bit_i),
        .phase_o    (phase),
        .strobe_o   (strobe_o),
        .rclk_o     (rclk_o),
        .dout_o     (data_o)
    );

    assign mode_o = mode;

endmodule

// File: tb/sim_bitclk_recovery.sv
`timescale 1ns/1ps
module sim_bitclk_recovery;

    localparam int OSR     = 64;
    localparam int NBITS   = 30;
    localparam int HALF    = OSR / 2;
    localparam int LIM     = OSR * NBITS;
    localparam int MED_LIM = OSR / 16;
    localparam int NAR_LIM = OSR / 64;
    localparam logic [1:0] M_ACQ = 2'd0, M_MED = 2'd1, M_NAR = 2'd2, M_HOLD = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic acq = 1'b1;
    logic hold_n = 1'b1;
    logic rclk, strobe, data;
    logic [1:0] mode;

    always #2.5 clk = ~clk;

    bitclk_recovery #(.OSR(OSR), .NARROW_BITS(NBITS)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_bit_i(rx_bit), .acq_i(acq),
        .hold_n_i(hold_n), .rclk_o(rclk), .strobe_o(strobe),
        .data_o(data), .mode_o(mode)
    );

    int n_run = 0;
    int n_fail = 0;

    // stimulus / model state
    int   t = 0;
    int   pos = 0;
    logic cur_bit = 1'b0;
    int   stall = 0;
    int   skip = 0;
    int   chk = 0;           // 0 none, 1 zero offset, 2 med step, 3 nar step, 4 hold
    string zero_tag = "R2";
    logic acq_v = 1'b1, hold_v = 1'b1;
    logic [1:0] exp_mode = M_ACQ;
    int   cnt_m = 0;
    int   last_off = 0, last_t = 0;
    logic pend = 1'b0, pend_bit = 1'b0;
    logic last_rclk = 1'b1, last_data = 1'b0;
    int   t_fall = -1, t_nar = -1;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp_v, t);
        end
    endtask

    function automatic logic [1:0] mode_ref(input logic a, input logic h, input bit done);
        if (a)       return M_ACQ;
        else if (!h) return M_HOLD;
        else if (done) return M_NAR;
        else         return M_MED;
    endfunction

    task automatic tick();
        int off;
        int d;
        @(negedge clk);
        t++;
        // advance the transmitted waveform
        if (stall > 0 && pos == OSR - 1) begin
            stall--;
        end else begin
            pos = (pos + 1) % OSR;
            if (pos == 0) cur_bit = (($urandom % 8) != 0) ? ~cur_bit : cur_bit;
        end
        // R1 R3 R6: mode against reference model
        check(mode == exp_mode, "R1/R3/R6 mode", mode, exp_mode);
        if (mode == M_NAR && t_nar < 0 && t_fall >= 0) t_nar = t;
        // R7: capture one cycle after strobe
        if (pend) begin
            check(data == pend_bit, "R7 data", data, pend_bit);
            pend = 1'b0;
        end
        // R7: data steady across rising recovered clock
        if (rclk && !last_rclk) check(data == last_data, "R7 rise", data, last_data);
        if (strobe) begin
            check(rclk == 1'b0, "R7 rclk low at strobe", rclk, 0);
            off = pos - HALF;
            d = off - last_off;
            if (skip > 0) skip--;
            else begin
                case (chk)
                    2: check(d <= MED_LIM && d >= -MED_LIM, "R4 step", d, MED_LIM);
                    3: check(d <= NAR_LIM && d >= -NAR_LIM, "R5 step", d, NAR_LIM);
                    4: begin
                        check(t - last_t == OSR, "R6 interval", t - last_t, OSR);
                        check(off == last_off, "R6 offset frozen", off, last_off);
                    end
                    default: ;
                endcase
            end
            if (chk == 1) check(off == 0, zero_tag, off, 0);
            last_off = off;
            last_t = t;
            if (pos >= 4 && pos <= OSR - 5) begin
                pend = 1'b1;
                pend_bit = cur_bit;
            end
        end
        last_rclk = rclk;
        last_data = data;
        // drive inputs
        if (acq && !acq_v) t_fall = t;
        rx_bit = cur_bit;
        acq = acq_v;
        hold_n = hold_v;
        exp_mode = mode_ref(acq_v, hold_v, cnt_m == LIM);
        if (acq_v) cnt_m = 0;
        else if (cnt_m != LIM) cnt_m++;
    endtask

    task automatic run_bits(input int n);
        repeat (n * OSR) tick();
    endtask

    task automatic do_stall(input int n);
        stall = n;
        skip = 2;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", t, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd589));
        repeat (4) @(negedge clk);
        // R8 reset state
        check(mode == M_ACQ, "R8 mode", mode, M_ACQ);
        check(rclk == 1'b1, "R8 rclk", rclk, 1);
        check(strobe == 1'b0, "R8 strobe", strobe, 0);
        check(data == 1'b0, "R8 data", data, 0);
        rst_n = 1'b1;
        exp_mode = M_ACQ;
        cnt_m = 0;

        // acquire, with hold asserted part of the time (R1 priority)
        run_bits(4);
        chk = 1; zero_tag = "R2 acquire";
        run_bits(6);
        hold_v = 1'b0;                      // R1: acquire still wins
        run_bits(3);
        check(mode == M_ACQ, "R1 acq over hold", mode, M_ACQ);
        hold_v = 1'b1;
        chk = 0; do_stall(20);
        run_bits(2);
        chk = 1; zero_tag = "R2 reacquire";
        run_bits(4);

        // medium bandwidth after acquire falls
        chk = 0; acq_v = 1'b0;
        run_bits(2);
        chk = 2; do_stall(12);
        run_bits(16);
        chk = 1; zero_tag = "R4 converge";
        run_bits(3);
        chk = 0;
        run_bits(12);
        check(t_nar - t_fall == LIM + 1, "R3 window", t_nar - t_fall, LIM + 1);

        // narrow bandwidth
        chk = 3; skip = 1; do_stall(5);
        run_bits(26);
        chk = 1; zero_tag = "R5 converge";
        run_bits(3);

        // hold: freewheel through a phase step
        chk = 0; hold_v = 1'b0;
        run_bits(2);
        chk = 4; skip = 1;
        run_bits(3);
        do_stall(9);
        run_bits(8);
        check(last_off == -9, "R6 drift kept", last_off, -9);
        hold_v = 1'b1;
        chk = 3; skip = 1;
        run_bits(34);
        chk = 1; zero_tag = "R5 after hold";
        run_bits(3);

        // hold released before window completes -> medium
        chk = 0; acq_v = 1'b1; hold_v = 1'b0;
        run_bits(2);
        acq_v = 1'b0;
        run_bits(3);
        check(mode == M_HOLD, "R6 hold entry", mode, M_HOLD);
        hold_v = 1'b1;
        tick(); tick();
        check(mode == M_MED, "R3 thaw to medium", mode, M_MED);

        // constrained random control sequences
        for (int i = 0; i < 25; i++) begin
            acq_v  = (($urandom % 4) == 0);
            hold_v = (($urandom % 3) != 0);
            if (($urandom % 5) == 0) begin
                stall = $urandom_range(1, 20);
            end
            repeat ($urandom_range(1, 300)) tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule